// File: doc/BRIEF.md
# Register Rename Status Table

This block keeps a small floating-point register file together with a per-register producer record. The record holds the tag of the reservation station that will write the register next. An issue stage presents two source register indices, one destination index and the tag of the station it has just allocated. In the same cycle the table answers for each source. It returns either the committed value, marked ready, or the tag of the station that still owes the value, marked waiting. On the next clock edge the destination's record takes the new tag. Because of this, a younger writer never stalls behind an older reader or an older writer of the same register.

Results return only through a broadcast bus that carries a station tag and a value. A register whose record holds that tag captures the value and becomes blank again. A register that has since been claimed by a newer writer ignores the broadcast. The reservation stations, the execution units and the arbitration for the bus lie outside this block.

Top module: `rename_status_table`

## Requirements
- R1: After a cycle with `rst_n` low, every register is blank (not pending) and holds zero, so each source lookup answers ready with value 0.
- R2: A lookup of a blank register returns ready=1, the stored value on the value output, and 0 on the tag output.
- R3: A lookup of a pending register, with no matching broadcast in that cycle, returns ready=0, the recorded producer tag on the tag output, and 0 on the value output.
- R4: An issue with `iss_valid` high makes its destination pending with `iss_tag` from the next cycle on. The source lookups in the issuing cycle see the state from before that issue, even when a source equals the destination.
- R5: A broadcast whose tag equals a pending register's recorded tag writes the broadcast value into that register and makes it blank from the next cycle on.
- R6: One broadcast updates every register whose record holds its tag.
- R7: A broadcast whose tag differs from a register's recorded tag leaves that register's value, pending flag and tag unchanged. This covers the case where the register's earlier producer was replaced by a newer writer.
- R8: When an issue and a matching broadcast target the same register in the same cycle, the register stays pending with the issue's new tag.
- R9: A source lookup of a pending register whose recorded tag is being broadcast in that same cycle returns ready=1 with the broadcast value.
- R10: With `iss_valid` low, the destination index and tag inputs change no register's record.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_src_a | input | IDX_W (2) | First source register index |
| iss_src_b | input | IDX_W (2) | Second source register index |
| iss_dst | input | IDX_W (2) | Destination register index |
| iss_tag | input | TAG_W (3) | Station tag allocated to the issuing instruction |
| bc_valid | input | 1 | A result is broadcast this cycle |
| bc_tag | input | TAG_W (3) | Tag of the station producing the broadcast |
| bc_value | input | DATA_W (32) | Broadcast result value |
| src_a_ready | output | 1 | First source value is available |
| src_a_tag | output | TAG_W (3) | Producer tag of the first source when waiting, else 0 |
| src_a_value | output | DATA_W (32) | First source value when ready, else 0 |
| src_b_ready | output | 1 | Second source value is available |
| src_b_tag | output | TAG_W (3) | Producer tag of the second source when waiting, else 0 |
| src_b_value | output | DATA_W (32) | Second source value when ready, else 0 |

## Verification
The bench builds the block with its defaults: four registers of 32 bits and eight station tags. With only four registers and eight tags, a long random mix of issues and broadcasts often aims an issue and a broadcast at the same register in one cycle. It also often sends broadcasts that carry a producer tag already replaced by a newer writer, and sends one tag that several registers share. These are the collision, stale-tag and multi-target cases behind R6 to R9, which wider settings would rarely reach. Directed sequences cover each of those cases once in a known order before the random phase.

// File: rtl/rst_pkg.sv
`timescale 1ns/1ps
// Package: default geometry shared by the rename status table and its checker.
// Assumes nothing beyond being compiled before every other file.
package rst_pkg;
    localparam int DEF_NUM_REGS     = 4;
    localparam int DEF_DATA_W       = 32;
    localparam int DEF_NUM_STATIONS = 8;

    // Answer of one source lookup.
    typedef enum logic {
        SRC_WAIT  = 1'b0,
        SRC_READY = 1'b1
    } src_state_e;
endpackage

// File: rtl/rst_entry.sv
`timescale 1ns/1ps
// Module: rst_entry
// One architectural register plus its producer record. It captures a
// broadcast value when the broadcast tag equals its recorded tag, and takes
// a new tag when an issue targets it. An issue beats a same-cycle matching
// broadcast for the record.
// Assumes: synchronous active-low reset; at most one issue per cycle.
module rst_entry #(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              claim,
    input  logic [TAG_W-1:0]  claim_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_value,
    output logic              pend,
    output logic [TAG_W-1:0]  tag,
    output logic [DATA_W-1:0] value,
    output logic              bc_hit
);

    // Broadcast addresses this register's current producer.
    always_comb begin
        bc_hit = pend && bc_valid && (tag == bc_tag);
    end

    // Record and value update: the new claim wins, and a hit clears the record otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend  <= 1'b0;
            tag   <= '0;
            value <= '0;
        end else begin
            if (bc_hit) begin
                value <= bc_value;
            end
            if (claim) begin
                pend <= 1'b1;
                tag  <= claim_tag;
            end else if (bc_hit) begin
                pend <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rst_lookup.sv
`timescale 1ns/1ps
// Module: rst_lookup
// A purely combinational source-operand port. It selects one register's
// record and returns its value when ready, or its producer tag when waiting.
// A broadcast that retires the register's producer in the same cycle is
// forwarded as a ready value.
// Assumes: flat vectors packed with register 0 in the low slice.
module rst_lookup
    import rst_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 32,
    parameter int TAG_W    = 3,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic [IDX_W-1:0]           src,
    input  logic [NUM_REGS-1:0]        pend_vec,
    input  logic [NUM_REGS-1:0]        hit_vec,
    input  logic [NUM_REGS*TAG_W-1:0]  tag_flat,
    input  logic [NUM_REGS*DATA_W-1:0] val_flat,
    input  logic [DATA_W-1:0]          bc_value,
    output logic                       ready,
    output logic [TAG_W-1:0]           tag,
    output logic [DATA_W-1:0]          value
);

    src_state_e state;

    // Decide ready or waiting, then drive the matching value or tag.
    always_comb begin
        if (!pend_vec[src] || hit_vec[src]) begin
            state = SRC_READY;
        end else begin
            state = SRC_WAIT;
        end
        ready = (state == SRC_READY);
        tag   = '0;
        value = '0;
        if (state == SRC_WAIT) begin
            tag = tag_flat[src*TAG_W +: TAG_W];
        end else if (pend_vec[src]) begin
            value = bc_value;
        end else begin
            value = val_flat[src*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/rename_status_table.sv
`timescale 1ns/1ps
// Module: rename_status_table
// Register file with a per-register producer-tag record. Two source lookups
// are answered combinationally from the pre-edge state. The destination is
// claimed for the issuing station at the clock edge. Broadcast results land
// only in registers still owned by the broadcasting tag.
// Assumes: one issue and one broadcast per cycle at most; station tags are
// unique among in-flight instructions.
module rename_status_table
    import rst_pkg::*;
#(
    parameter int NUM_REGS     = DEF_NUM_REGS,
    parameter int DATA_W       = DEF_DATA_W,
    parameter int NUM_STATIONS = DEF_NUM_STATIONS,
    localparam int IDX_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int TAG_W       = (NUM_STATIONS > 1) ? $clog2(NUM_STATIONS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [IDX_W-1:0]  iss_src_a,
    input  logic [IDX_W-1:0]  iss_src_b,
    input  logic [IDX_W-1:0]  iss_dst,
    input  logic [TAG_W-1:0]  iss_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_value,
    output logic              src_a_ready,
    output logic [TAG_W-1:0]  src_a_tag,
    output logic [DATA_W-1:0] src_a_value,
    output logic              src_b_ready,
    output logic [TAG_W-1:0]  src_b_tag,
    output logic [DATA_W-1:0] src_b_value
);

    logic [NUM_REGS-1:0]        pend_vec;
    logic [NUM_REGS-1:0]        hit_vec;
    logic [NUM_REGS-1:0]        claim_vec;
    logic [NUM_REGS*TAG_W-1:0]  tag_flat;
    logic [NUM_REGS*DATA_W-1:0] val_flat;

    // One storage entry per architectural register.
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        // Decode the destination into a per-register claim strobe.
        always_comb begin
            claim_vec[r] = iss_valid && (iss_dst == IDX_W'(r));
        end

        rst_entry #(
            .DATA_W (DATA_W),
            .TAG_W  (TAG_W)
        ) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .claim     (claim_vec[r]),
            .claim_tag (iss_tag),
            .bc_valid  (bc_valid),
            .bc_tag    (bc_tag),
            .bc_value  (bc_value),
            .pend      (pend_vec[r]),
            .tag       (tag_flat[r*TAG_W +: TAG_W]),
            .value     (val_flat[r*DATA_W +: DATA_W]),
            .bc_hit    (hit_vec[r])
        );
    end

    rst_lookup #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .TAG_W    (TAG_W)
    ) u_look_a (
        .src      (iss_src_a),
        .pend_vec (pend_vec),
        .hit_vec  (hit_vec),
        .tag_flat (tag_flat),
        .val_flat (val_flat),
        .bc_value (bc_value),
        .ready    (src_a_ready),
        .tag      (src_a_tag),
        .value    (src_a_value)
    );

    rst_lookup #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .TAG_W    (TAG_W)
    ) u_look_b (
        .src      (iss_src_b),
        .pend_vec (pend_vec),
        .hit_vec  (hit_vec),
        .tag_flat (tag_flat),
        .val_flat (val_flat),
        .bc_value (bc_value),
        .ready    (src_b_ready),
        .tag      (src_b_tag),
        .value    (src_b_value)
    );

endmodule

// File: rtl/rst_checker.sv
`timescale 1ns/1ps
// Module: rst_checker
// Temporal properties of the rename status table, bound onto its top.
// Assumes: it sees the top's flattened per-register state vectors.
module rst_checker #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 32,
    parameter int TAG_W    = 3,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       iss_valid,
    input logic [IDX_W-1:0]           iss_src_a,
    input logic [IDX_W-1:0]           iss_dst,
    input logic [TAG_W-1:0]           iss_tag,
    input logic                       bc_valid,
    input logic [TAG_W-1:0]           bc_tag,
    input logic [DATA_W-1:0]          bc_value,
    input logic                       src_a_ready,
    input logic [TAG_W-1:0]           src_a_tag,
    input logic [NUM_REGS-1:0]        pend_vec,
    input logic [NUM_REGS*TAG_W-1:0]  tag_flat,
    input logic [NUM_REGS*DATA_W-1:0] val_flat
);

    logic             last_v;
    logic [IDX_W-1:0] last_dst;
    logic [TAG_W-1:0] last_tag;

    // Remember the previous cycle's issue for the claim check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_v   <= 1'b0;
            last_dst <= '0;
            last_tag <= '0;
        end else begin
            last_v   <= iss_valid;
            last_dst <= iss_dst;
            last_tag <= iss_tag;
        end
    end

    // R1
    reset_blank_chk: assert property (@(posedge clk)
        !rst_n |=> (pend_vec == '0) && (val_flat == '0));

    // R3
    wait_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !src_a_ready |-> pend_vec[iss_src_a]
                         && (src_a_tag == tag_flat[iss_src_a*TAG_W +: TAG_W]));

    // R4
    claim_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_v |-> pend_vec[last_dst]
                   && (tag_flat[last_dst*TAG_W +: TAG_W] == last_tag));

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_chk
        // R5
        retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bc_valid && pend_vec[r] && (tag_flat[r*TAG_W +: TAG_W] == bc_tag)
             && !(iss_valid && (iss_dst == IDX_W'(r))))
            |=> !pend_vec[r] && (val_flat[r*DATA_W +: DATA_W] == $past(bc_value)));

        // R7
        stale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!(iss_valid && (iss_dst == IDX_W'(r)))
             && !(bc_valid && pend_vec[r] && (tag_flat[r*TAG_W +: TAG_W] == bc_tag)))
            |=> $stable(pend_vec[r]) && $stable(tag_flat[r*TAG_W +: TAG_W])
                && $stable(val_flat[r*DATA_W +: DATA_W]));
    end

endmodule

bind rename_status_table rst_checker #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .TAG_W    (TAG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .iss_valid   (iss_valid),
    .iss_src_a   (iss_src_a),
    .iss_dst     (iss_dst),
    .iss_tag     (iss_tag),
    .bc_valid    (bc_valid),
    .bc_tag      (bc_tag),
    .bc_value    (bc_value),
    .src_a_ready (src_a_ready),
    .src_a_tag   (src_a_tag),
    .pend_vec    (pend_vec),
    .tag_flat    (tag_flat),
    .val_flat    (val_flat)
);

// File: tb/rename_status_table_bench.sv
`timescale 1ns/1ps
// Bench: behavioural reference model of the rename status table, compared
// against the lookup outputs in every driven cycle.
module rename_status_table_bench;

    localparam int NREG = 4;
    localparam int DW   = 32;
    localparam int NST  = 8;
    localparam int IW   = 2;
    localparam int TW   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iss_valid = 1'b0;
    logic [IW-1:0] iss_src_a = '0;
    logic [IW-1:0] iss_src_b = '0;
    logic [IW-1:0] iss_dst = '0;
    logic [TW-1:0] iss_tag = '0;
    logic          bc_valid = 1'b0;
    logic [TW-1:0] bc_tag = '0;
    logic [DW-1:0] bc_value = '0;
    logic          src_a_ready, src_b_ready;
    logic [TW-1:0] src_a_tag, src_b_tag;
    logic [DW-1:0] src_a_value, src_b_value;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Reference state.
    bit          m_pend [NREG];
    int unsigned m_tag  [NREG];
    logic [DW-1:0] m_val [NREG];

    always #2 clk = ~clk;

    rename_status_table #(
        .NUM_REGS     (NREG),
        .DATA_W       (DW),
        .NUM_STATIONS (NST)
    ) u_rename_status_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .iss_valid   (iss_valid),
        .iss_src_a   (iss_src_a),
        .iss_src_b   (iss_src_b),
        .iss_dst     (iss_dst),
        .iss_tag     (iss_tag),
        .bc_valid    (bc_valid),
        .bc_tag      (bc_tag),
        .bc_value    (bc_value),
        .src_a_ready (src_a_ready),
        .src_a_tag   (src_a_tag),
        .src_a_value (src_a_value),
        .src_b_ready (src_b_ready),
        .src_b_tag   (src_b_tag),
        .src_b_value (src_b_value)
    );

    task automatic check(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected answer of one lookup from the model plus the same-cycle broadcast.
    task automatic check_src(string req, string port, int s, bit bv, int unsigned bt,
                             logic [DW-1:0] bval, logic rdy, logic [TW-1:0] tg, logic [DW-1:0] vl);
        bit e_rdy;
        logic [DW-1:0] e_val;
        int unsigned e_tag;
        e_rdy = !m_pend[s] || (bv && m_tag[s] == bt);
        e_tag = e_rdy ? 0 : m_tag[s];
        e_val = !e_rdy ? '0 : (m_pend[s] ? bval : m_val[s]);
        check(req, {port, " ready"}, DW'(rdy), DW'(e_rdy));
        check(req, {port, " tag"},   DW'(tg),  DW'(e_tag));
        check(req, {port, " value"}, vl, e_val);
    endtask

    // Drive one cycle, compare lookups, then advance the model past the edge.
    task automatic step(string req, bit iv, int sa, int sb, int d, int unsigned t,
                        bit bv, int unsigned bt, logic [DW-1:0] bval);
        bit hit [NREG];
        @(negedge clk);
        iss_valid = iv; iss_src_a = IW'(sa); iss_src_b = IW'(sb);
        iss_dst = IW'(d); iss_tag = TW'(t);
        bc_valid = bv; bc_tag = TW'(bt); bc_value = bval;
        #1;
        check_src(req, "a", sa, bv, bt, bval, src_a_ready, src_a_tag, src_a_value);
        check_src(req, "b", sb, bv, bt, bval, src_b_ready, src_b_tag, src_b_value);
        @(posedge clk);
        for (int r = 0; r < NREG; r++) hit[r] = m_pend[r] && bv && (m_tag[r] == bt);
        for (int r = 0; r < NREG; r++) begin
            if (hit[r]) m_val[r] = bval;
            if (iv && d == r) begin
                m_pend[r] = 1'b1;
                m_tag[r]  = t;
            end else if (hit[r]) begin
                m_pend[r] = 1'b0;
            end
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < NREG; r++) begin
            m_pend[r] = 1'b0; m_tag[r] = 0; m_val[r] = '0;
        end
        // Dirty the state first, then reset.
        rst_n = 1'b1;
        @(negedge clk);
        iss_valid = 1'b1; iss_dst = 2'd2; iss_tag = 3'd3;
        @(negedge clk);
        iss_valid = 1'b0; rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: everything blank and zero after reset.
        for (int r = 0; r < NREG; r++) step("R1", 0, r, NREG-1-r, 0, 0, 0, 0, '0);

        // R4: claim r1 with tag 5; lookup of r1 in the same cycle sees blank.
        step("R4", 1, 1, 2, 1, 5, 0, 0, '0);
        // R3: r1 now waits on tag 5.
        step("R3", 0, 1, 1, 0, 0, 0, 0, '0);
        // R9: broadcast tag 5 forwarded to the same-cycle lookup.
        step("R9", 0, 1, 0, 0, 0, 1, 5, 32'hAAAA1111);
        // R5 / R2: r1 now holds the value, blank.
        step("R5", 0, 1, 1, 0, 0, 0, 0, '0);

        // R6: two registers share tag 2, one broadcast fills both.
        step("R6", 1, 0, 3, 0, 2, 0, 0, '0);
        step("R6", 1, 0, 3, 3, 2, 0, 0, '0);
        step("R6", 0, 0, 3, 0, 0, 1, 2, 32'h1234_5678);
        step("R6", 0, 0, 3, 0, 0, 0, 0, '0);

        // R7: r2 claimed by tag 1 then tag 4; a tag 1 broadcast is stale.
        step("R7", 1, 2, 2, 2, 1, 0, 0, '0);
        step("R7", 1, 2, 2, 2, 4, 0, 0, '0);
        step("R7", 0, 1, 2, 0, 0, 1, 1, 32'hDEAD_0001);
        step("R7", 0, 2, 1, 0, 0, 0, 0, '0);
        step("R7", 0, 2, 2, 0, 0, 1, 4, 32'h0000_BEEF);
        step("R2", 0, 2, 1, 0, 0, 0, 0, '0);

        // R8 / R9: claim r0 with 6, then reclaim with 7 while 6 broadcasts.
        step("R8", 1, 3, 3, 0, 6, 0, 0, '0);
        step("R9", 1, 0, 0, 0, 7, 1, 6, 32'h6666_6666);
        step("R8", 0, 0, 0, 0, 0, 0, 0, '0);

        // R10: idle issue strobe with live index/tag changes nothing.
        step("R10", 0, 3, 1, 3, 7, 0, 0, '0);
        step("R10", 0, 3, 1, 0, 0, 0, 0, '0);

        // Random mix covering R2/R3 and the collision cases.
        for (int i = 0; i < 400; i++) begin
            int sa = $urandom_range(NREG-1);
            step(m_pend[sa] ? "R3" : "R2",
                 $urandom_range(1) == 1, sa, $urandom_range(NREG-1),
                 $urandom_range(NREG-1), $urandom_range(NST-1),
                 $urandom_range(2) != 0, $urandom_range(NST-1), DW'($urandom));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule